// File: doc/BRIEF.md
# Partitioned Performance Counter Bank

This block holds six event counters and splits them at a boundary that software can move at run time. Counters whose index is below the boundary form a guest group. Guest software at the two lowest privilege levels may reach them, subject to a user-enable input at the lowest level. Counters at or above the boundary form a hypervisor group that only the hypervisor level and above may touch. Each group has its own global count enable. In secure state the partition does not apply.

A single control word sets the boundary and a trap bit. It is written through a configuration port that only privilege levels 2 and 3 may use. A combinational classification port takes a privilege level, a security state, an access kind and a counter index. It answers with a permit flag and a trap-to-hypervisor flag, so the surrounding pipeline can route the access. Instruction decode, event selection and interrupts are outside the block.

Top module: `pmu_part_bank`

## Requirements
- R1: After reset the control word reads 6'b000110: trap bit clear, boundary 6. All counters read 0, and no overflow pulse or illegal-write flag is set.
- R2: The control word is `cfg_wdata[5]` = trap enable and `cfg_wdata[4:0]` = boundary. A write with `cfg_wr_el` of 2 or 3 takes effect on the next clock edge. A write with level 0 or 1 leaves the word unchanged and raises `cfg_illegal` for exactly one cycle after that edge.
- R3: `cfg_rdata` returns the boundary exactly as last written, including 0 and values from 7 to 31.
- R4: In non-secure state, a counter access (`chk_kind`=0) to an index below the effective boundary is permitted from levels 1, 2 and 3. From level 0 it is permitted only when `user_en` is 1; otherwise it is refused without a trap.
- R5: In non-secure state, a counter access from level 0 or 1 to an index from the effective boundary up to 5 gives trap=1 and permit=0. The same access from level 2 or 3 is permitted.
- R6: The effective boundary is min(boundary, 6). A boundary of 0 makes every counter trap for non-secure levels 0 and 1, and any value above 6 behaves like 6.
- R7: In secure state (`chk_nonsec`=0) no counter access traps. Levels 1 to 3 are permitted, and level 0 is permitted only when `user_en` is 1.
- R8: A control-word access (`chk_kind`=1) from non-secure level 0 or 1 gives trap=1 and permit=0 while the trap bit is set. Every other control-word access is permitted.
- R9: When `cnt_nonsec`=1, a counter below the effective boundary counts its event only while `gen_en` is 1. A counter at or above it counts only while `hyp_en` is 1. When `cnt_nonsec`=0, all counters are gated by `gen_en` alone.
- R10: A counter at its maximum value wraps to 0 on its next counted event. Its `ovf_pulse` bit is 1 for exactly the cycle after that edge.
- R11: A counter access with an index of 6 or 7 gives permit=0 and trap=0, and permit and trap are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_el | input | 2 | Privilege level of the writer (0..3) |
| cfg_wdata | input | 6 | [5] trap enable, [4:0] boundary |
| cfg_rdata | output | 6 | Raw control word |
| cfg_illegal | output | 1 | Write from level 0/1 was dropped (one-cycle pulse) |
| gen_en | input | 1 | Global enable of guest group |
| hyp_en | input | 1 | Global enable of hypervisor group |
| user_en | input | 1 | Level-0 access enable |
| cnt_nonsec | input | 1 | Security state governing count gating |
| evt_in | input | NUM_CTR | One event strobe per counter |
| chk_el | input | 2 | Requesting privilege level |
| chk_nonsec | input | 1 | Requester is non-secure |
| chk_kind | input | 1 | 0 = counter access, 1 = control-word access |
| chk_idx | input | 3 | Counter index |
| chk_permit | output | 1 | Access may proceed |
| chk_trap | output | 1 | Access must trap to the hypervisor |
| ctr_val | output | NUM_CTR*CTR_W | Counter values, counter i at bits [i*CTR_W +: CTR_W] |
| ovf_pulse | output | NUM_CTR | Per-counter wrap pulse |

## Verification
Several properties are checked on every cycle:
- Permit and trap are never raised together.
- Secure counter accesses never trap.
- An index in the hypervisor group traps for non-secure guest levels.
- Writes from low levels leave the word unchanged and raise the flag.
- Idle counters hold their value, and an overflow pulse always coincides with a zero count.

Other behaviours only the bench scenarios can show: the saturation of boundaries above six, the raw readback of those values, the level-0 dependence on the user enable, the group-enable gating, and the exact cycle of a wrap on a narrowed counter.

// File: rtl/pmu_part_pkg.sv
package pmu_part_pkg;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } priv_lvl_e;

    localparam int unsigned CW_W      = 6;
    localparam int unsigned CW_TRAP_B = 5;

    function automatic logic is_guest_lvl(input logic [1:0] lvl);
        return (lvl == LVL_USER) || (lvl == LVL_KERN);
    endfunction

endpackage

// File: rtl/pmu_part_cfg.sv
module pmu_part_cfg
    import pmu_part_pkg::*;
#(
    parameter int unsigned NUM_CTR = 6,
    parameter int unsigned BOUND_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_el,
    input  logic [BOUND_W:0]   wdata,
    output logic [BOUND_W-1:0] bound,
    output logic               trap_cw,
    output logic               illegal
);

    typedef struct packed {
        logic [BOUND_W-1:0] bound;
        logic               trap_cw;
        logic               illegal;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        if (wr_en) begin
            if (is_guest_lvl(wr_el)) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.bound   = wdata[BOUND_W-1:0];
                st_d.trap_cw = wdata[BOUND_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bound   <= BOUND_W'(NUM_CTR);
            st_q.trap_cw <= 1'b0;
            st_q.illegal <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bound   = st_q.bound;
    assign trap_cw = st_q.trap_cw;
    assign illegal = st_q.illegal;

endmodule

// File: rtl/pmu_part_access.sv
module pmu_part_access
    import pmu_part_pkg::*;
#(
    parameter int unsigned NUM_CTR = 6,
    parameter int unsigned BOUND_W = 5,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [BOUND_W-1:0] bound,
    input  logic               trap_cw,
    input  logic               user_en,
    input  logic [1:0]         lvl,
    input  logic               nonsec,
    input  logic               kind,
    input  logic [IDX_W-1:0]   idx,
    output logic               permit,
    output logic               trap
);

    localparam logic [BOUND_W-1:0] NUM_B = BOUND_W'(NUM_CTR);

    logic [BOUND_W-1:0] eff_bound;
    logic [BOUND_W-1:0] idx_w;
    logic               idx_ok;
    logic               in_guest;
    logic               guest;
    logic               lvl_ok;

    always_comb begin
        eff_bound = (bound > NUM_B) ? NUM_B : bound;
        idx_w     = BOUND_W'(idx);
        idx_ok    = idx_w < NUM_B;
        in_guest  = idx_w < eff_bound;
        guest     = is_guest_lvl(lvl);
        lvl_ok    = (lvl != LVL_USER) || user_en;
        permit    = 1'b0;
        trap      = 1'b0;
        if (kind) begin
            trap   = nonsec && guest && trap_cw;
            permit = !trap;
        end else if (idx_ok) begin
            if (!nonsec || !guest) begin
                permit = lvl_ok;
            end else if (in_guest) begin
                permit = lvl_ok;
            end else begin
                trap = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pmu_part_ctr.sv
module pmu_part_ctr #(
    parameter int unsigned CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CTR_W-1:0] cnt,
    output logic             ovf
);

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             ovf;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.ovf = &st_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

endmodule

// File: rtl/pmu_part_bank.sv
module pmu_part_bank
    import pmu_part_pkg::*;
#(
    parameter int unsigned NUM_CTR = 6,
    parameter int unsigned CTR_W   = 32,
    parameter int unsigned BOUND_W = 5,
    parameter int unsigned IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_en,
    input  logic [1:0]               cfg_wr_el,
    input  logic [BOUND_W:0]         cfg_wdata,
    output logic [BOUND_W:0]         cfg_rdata,
    output logic                     cfg_illegal,
    input  logic                     gen_en,
    input  logic                     hyp_en,
    input  logic                     user_en,
    input  logic                     cnt_nonsec,
    input  logic [NUM_CTR-1:0]       evt_in,
    input  logic [1:0]               chk_el,
    input  logic                     chk_nonsec,
    input  logic                     chk_kind,
    input  logic [IDX_W-1:0]         chk_idx,
    output logic                     chk_permit,
    output logic                     chk_trap,
    output logic [NUM_CTR*CTR_W-1:0] ctr_val,
    output logic [NUM_CTR-1:0]       ovf_pulse
);

    logic [BOUND_W-1:0] bound;
    logic               trap_cw;
    logic [NUM_CTR-1:0] inc;

    pmu_part_cfg #(
        .NUM_CTR (NUM_CTR),
        .BOUND_W (BOUND_W)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_el   (cfg_wr_el),
        .wdata   (cfg_wdata),
        .bound   (bound),
        .trap_cw (trap_cw),
        .illegal (cfg_illegal)
    );

    assign cfg_rdata = {trap_cw, bound};

    pmu_part_access #(
        .NUM_CTR (NUM_CTR),
        .BOUND_W (BOUND_W),
        .IDX_W   (IDX_W)
    ) acc_i (
        .bound   (bound),
        .trap_cw (trap_cw),
        .user_en (user_en),
        .lvl     (chk_el),
        .nonsec  (chk_nonsec),
        .kind    (chk_kind),
        .idx     (chk_idx),
        .permit  (chk_permit),
        .trap    (chk_trap)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        // bound above NUM_CTR leaves no index in the upper group
        logic upper;
        assign upper  = cnt_nonsec && (BOUND_W'(i) >= bound);
        assign inc[i] = evt_in[i] && (upper ? hyp_en : gen_en);

        pmu_part_ctr #(
            .CTR_W (CTR_W)
        ) ctr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[i]),
            .cnt   (ctr_val[i*CTR_W +: CTR_W]),
            .ovf   (ovf_pulse[i])
        );
    end

endmodule

// File: rtl/pmu_part_sva.sv
module pmu_part_sva #(
    parameter int unsigned NUM_CTR = 6,
    parameter int unsigned CTR_W   = 32,
    parameter int unsigned BOUND_W = 5,
    parameter int unsigned IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_wr_en,
    input logic [1:0]               cfg_wr_el,
    input logic [BOUND_W:0]         cfg_wdata,
    input logic [BOUND_W:0]         cfg_rdata,
    input logic                     cfg_illegal,
    input logic                     chk_nonsec,
    input logic                     chk_kind,
    input logic [1:0]               chk_el,
    input logic [IDX_W-1:0]         chk_idx,
    input logic                     chk_permit,
    input logic                     chk_trap,
    input logic [NUM_CTR-1:0]       evt_in,
    input logic [NUM_CTR*CTR_W-1:0] ctr_val,
    input logic [NUM_CTR-1:0]       ovf_pulse
);

    // R1
    reset_val_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg_rdata == (BOUND_W+1)'(NUM_CTR)) && !cfg_illegal && (ovf_pulse == '0));

    // R2
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_el < 2'd2) |=> cfg_illegal && $stable(cfg_rdata));

    // R2
    high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_el >= 2'd2) |=> (cfg_rdata == $past(cfg_wdata)) && !cfg_illegal);

    // R11
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_permit && chk_trap));

    // R5
    upper_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_nonsec && !chk_kind && chk_el < 2'd2 && BOUND_W'(chk_idx) < BOUND_W'(NUM_CTR)
         && BOUND_W'(chk_idx) >= cfg_rdata[BOUND_W-1:0]) |-> chk_trap);

    // R7
    secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_nonsec && !chk_kind) |-> !chk_trap);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_c
        // R10
        ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_pulse[i] |-> (ctr_val[i*CTR_W +: CTR_W] == '0));

        // R9
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_in[i] |=> $stable(ctr_val[i*CTR_W +: CTR_W]) && !ovf_pulse[i]);
    end

endmodule

bind pmu_part_bank pmu_part_sva #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .BOUND_W (BOUND_W),
    .IDX_W   (IDX_W)
) sva_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_el   (cfg_wr_el),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .cfg_illegal (cfg_illegal),
    .chk_nonsec  (chk_nonsec),
    .chk_kind    (chk_kind),
    .chk_el      (chk_el),
    .chk_idx     (chk_idx),
    .chk_permit  (chk_permit),
    .chk_trap    (chk_trap),
    .evt_in      (evt_in),
    .ctr_val     (ctr_val),
    .ovf_pulse   (ovf_pulse)
);

// File: tb/pmu_part_bank_tb.sv
module pmu_part_bank_tb_top;

    localparam int unsigned NC = 6;
    localparam int unsigned CW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr_en = 1'b0;
    logic [1:0]      cfg_wr_el = 2'd0;
    logic [5:0]      cfg_wdata = '0;
    logic [5:0]      cfg_rdata;
    logic            cfg_illegal;
    logic            gen_en = 1'b0;
    logic            hyp_en = 1'b0;
    logic            user_en = 1'b0;
    logic            cnt_nonsec = 1'b0;
    logic [NC-1:0]   evt_in = '0;
    logic [1:0]      chk_el = 2'd0;
    logic            chk_nonsec = 1'b0;
    logic            chk_kind = 1'b0;
    logic [2:0]      chk_idx = 3'd0;
    logic            chk_permit;
    logic            chk_trap;
    logic [NC*CW-1:0] ctr_val;
    logic [NC-1:0]   ovf_pulse;

    int n_chk = 0;
    int n_err = 0;
    int exp_c [NC];

    always #2 clk = ~clk;

    pmu_part_bank #(.NUM_CTR(NC), .CTR_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_el(cfg_wr_el),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_illegal(cfg_illegal),
        .gen_en(gen_en), .hyp_en(hyp_en), .user_en(user_en), .cnt_nonsec(cnt_nonsec),
        .evt_in(evt_in), .chk_el(chk_el), .chk_nonsec(chk_nonsec), .chk_kind(chk_kind),
        .chk_idx(chk_idx), .chk_permit(chk_permit), .chk_trap(chk_trap),
        .ctr_val(ctr_val), .ovf_pulse(ovf_pulse)
    );

    typedef struct packed {
        logic [5:0] cw;
        logic       ns;
        logic       kind;
        logic [1:0] el;
        logic [2:0] idx;
        logic       usr;
        logic       perm;
        logic       trp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{6'd6,  1'b1, 1'b0, 2'd1, 3'd5, 1'b0, 1'b1, 1'b0, 4'd4},
        '{6'd6,  1'b1, 1'b0, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 4'd4},
        '{6'd6,  1'b1, 1'b0, 2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 4'd4},
        '{6'd3,  1'b1, 1'b0, 2'd1, 3'd3, 1'b0, 1'b0, 1'b1, 4'd5},
        '{6'd3,  1'b1, 1'b0, 2'd0, 3'd5, 1'b1, 1'b0, 1'b1, 4'd5},
        '{6'd3,  1'b1, 1'b0, 2'd2, 3'd5, 1'b0, 1'b1, 1'b0, 4'd5},
        '{6'd3,  1'b1, 1'b0, 2'd1, 3'd2, 1'b0, 1'b1, 1'b0, 4'd4},
        '{6'd0,  1'b1, 1'b0, 2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 4'd6},
        '{6'd0,  1'b1, 1'b0, 2'd3, 3'd0, 1'b0, 1'b1, 1'b0, 4'd5},
        '{6'd20, 1'b1, 1'b0, 2'd1, 3'd5, 1'b0, 1'b1, 1'b0, 4'd6},
        '{6'd31, 1'b1, 1'b0, 2'd0, 3'd5, 1'b1, 1'b1, 1'b0, 4'd6},
        '{6'd0,  1'b0, 1'b0, 2'd1, 3'd4, 1'b0, 1'b1, 1'b0, 4'd7},
        '{6'd0,  1'b0, 1'b0, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 4'd7},
        '{6'd38, 1'b1, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 4'd8},
        '{6'd38, 1'b1, 1'b1, 2'd2, 3'd0, 1'b0, 1'b1, 1'b0, 4'd8},
        '{6'd38, 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd8},
        '{6'd6,  1'b1, 1'b1, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd8},
        '{6'd6,  1'b1, 1'b0, 2'd2, 3'd6, 1'b0, 1'b0, 1'b0, 4'd11}
    };

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] el, input logic [5:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_el = el;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic check_ctrs(input string req);
        for (int i = 0; i < NC; i++) begin
            check(req, $sformatf("counter %0d", i), longint'(ctr_val[i*CW +: CW]), longint'(exp_c[i]));
        end
    endtask

    task automatic run_events(input logic [NC-1:0] ev, input int cyc);
        @(negedge clk);
        evt_in = ev;
        repeat (cyc) @(negedge clk);
        evt_in = '0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NC; i++) exp_c[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "control word", longint'(cfg_rdata), 6);
        check("R1", "illegal flag", longint'(cfg_illegal), 0);
        check("R1", "overflow pulses", longint'(ovf_pulse), 0);
        check_ctrs("R1");

        // table walk: R4 R5 R6 R7 R8 R11
        for (int v = 0; v < NV; v++) begin
            wr_cfg(2'd2, VEC[v].cw);
            user_en    = VEC[v].usr;
            chk_nonsec = VEC[v].ns;
            chk_kind   = VEC[v].kind;
            chk_el     = VEC[v].el;
            chk_idx    = VEC[v].idx;
            #1;
            check($sformatf("R%0d", VEC[v].req), $sformatf("vector %0d permit", v), longint'(chk_permit), longint'(VEC[v].perm));
            check($sformatf("R%0d", VEC[v].req), $sformatf("vector %0d trap", v), longint'(chk_trap), longint'(VEC[v].trp));
        end

        // R3 raw readback of out-of-range boundaries
        wr_cfg(2'd3, 6'd0);
        check("R3", "readback of 0", longint'(cfg_rdata), 0);
        wr_cfg(2'd2, 6'd27);
        check("R3", "readback of 27", longint'(cfg_rdata), 27);

        // R2 illegal write from level 1, then from level 0
        wr_cfg(2'd1, 6'd2);
        check("R2", "illegal pulse", longint'(cfg_illegal), 1);
        check("R2", "word unchanged", longint'(cfg_rdata), 27);
        @(negedge clk);
        check("R2", "pulse one cycle", longint'(cfg_illegal), 0);
        wr_cfg(2'd0, 6'd33);
        check("R2", "level 0 dropped", longint'(cfg_rdata), 27);
        wr_cfg(2'd2, 6'd3);
        check("R2", "legal write, no flag", longint'(cfg_illegal), 0);

        // R9 group gating, boundary 3, non-secure
        cnt_nonsec = 1'b1;
        gen_en = 1'b1; hyp_en = 1'b0;
        run_events('1, 5);
        for (int i = 0; i < 3; i++) exp_c[i] += 5;
        check_ctrs("R9");
        gen_en = 1'b0; hyp_en = 1'b1;
        run_events('1, 4);
        for (int i = 3; i < NC; i++) exp_c[i] += 4;
        check_ctrs("R9");
        // R9 secure: general enable only, even with boundary 0
        wr_cfg(2'd2, 6'd0);
        cnt_nonsec = 1'b0;
        gen_en = 1'b1; hyp_en = 1'b0;
        run_events('1, 2);
        for (int i = 0; i < NC; i++) exp_c[i] += 2;
        check_ctrs("R9");

        // R10 wrap of counter 0
        @(negedge clk);
        evt_in = 6'b000001;
        repeat ((1 << CW) - 1 - exp_c[0]) @(negedge clk);
        check("R10", "counter at max", longint'(ctr_val[0 +: CW]), longint'((1 << CW) - 1));
        check("R10", "no early pulse", longint'(ovf_pulse), 0);
        @(negedge clk);
        evt_in = '0;
        check("R10", "wrapped to 0", longint'(ctr_val[0 +: CW]), 0);
        check("R10", "pulse on wrap", longint'(ovf_pulse), 1);
        @(negedge clk);
        check("R10", "pulse ends", longint'(ovf_pulse), 0);

        finish_run();
    end

endmodule